// File: doc/BRIEF.md
# GPIO Interrupt Routing Mux

This block places the interrupt lines of three GPIO controllers onto a fixed, smaller set of processor interrupt inputs. Two controllers are hard (controller 0 with 14 lines, controller 1 with 24 lines). The third sits in the fabric and has 32 lines. There are 38 exclusive ("direct") outputs and 3 merged ("shared") outputs, one shared output for each controller.

A 32-bit routing register holds one steering bit per contested output slot. Each bit settles a fixed pairing between one hard line and one fabric line. The line that wins the slot drives that direct output alone. The line that loses is ORed into the shared output of its own controller. Controller 1 lines 18 to 23 have six slots of their own and the register never affects them.

Software writes the register through a plain write strobe and reads it back on a read bus. The interrupt path from the GPIO inputs to the outputs has no flops, so there is no valid/ready handshake on it and nothing can apply back-pressure. Interrupt inputs are sampled by whatever logic lies downstream.

Top module: `gpio_irq_router`

## Requirements
- R1: During and after reset the routing register is 0x00000000. `cfg_rdata` shows 0, which makes every controller 0 and controller 1 line direct.
- R2: When `cfg_we` is high at a rising clock edge, `cfg_wdata` is captured at that edge. From then on `cfg_rdata` shows the value and the routing follows it.
- R3: When `cfg_we` is low, the register and `cfg_rdata` keep their value.
- R4: When register bit k is 0, direct output k carries the hard line. For k = 0..13 that is controller 0 line k; for k = 14..31 it is controller 1 line k-14. Fabric line k is then ORed into `shared_irq[2]`.
- R5: When register bit k is 1, direct output k carries fabric line k. The paired hard line is then ORed into the shared output of its controller: `shared_irq[0]` for bits 0..13 and `shared_irq[1]` for bits 14..31.
- R6: Direct outputs 32..37 always carry controller 1 lines 18..23, whatever the register holds.
- R7: `shared_irq[0]` is the OR of the controller 0 lines whose bit is 1. `shared_irq[1]` is the OR of controller 1 lines 0..17 whose bit (14+n) is 1. Controller 1 lines 18..23 never reach a shared output.
- R8: `shared_irq[2]` is the OR of the fabric lines whose register bit is 0.
- R9: A change on an interrupt input shows on the outputs in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the routing register |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 32 | Register write value |
| cfg_rdata | output | 32 | Current register value |
| irq_c0 | input | 14 | Controller 0 interrupt lines |
| irq_c1 | input | 24 | Controller 1 interrupt lines |
| irq_c2 | input | 32 | Fabric controller interrupt lines |
| direct_irq | output | 38 | Exclusive interrupt outputs |
| shared_irq | output | 3 | Merged outputs: [0] controller 0, [1] controller 1, [2] fabric |

## Verification
A register write is due one edge after the strobe. The bench drives the strobe after a falling edge and reads `cfg_rdata` after the next falling edge, once the capturing rising edge has passed. The routed outputs are combinational, so they are due in the same cycle as an input change. The bench applies each input pattern away from the clock edge and compares one time unit later, with no edge in between. Single-hot patterns over all 70 lines, under both all-zero and all-one register values, isolate each pairing.

// File: rtl/girt_pkg.sv
package girt_pkg;
  localparam int unsigned C0_LINES_DEF = 14;
  localparam int unsigned C1_LINES_DEF = 24;
  localparam int unsigned C1_MUXED_DEF = 18;
  localparam int unsigned C2_LINES_DEF = 32;

  typedef enum logic [1:0] {
    SH_C0  = 2'd0,
    SH_C1  = 2'd1,
    SH_FAB = 2'd2
  } shared_idx_e;
endpackage

// File: rtl/girt_cfg_reg.sv
module girt_cfg_reg #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= wdata;
  end
endmodule

// File: rtl/girt_pair_steer.sv
module girt_pair_steer #(
  parameter int unsigned SLOTS = 32
) (
  input  logic [SLOTS-1:0] sel,
  input  logic [SLOTS-1:0] hard_in,
  input  logic [SLOTS-1:0] fab_in,
  output logic [SLOTS-1:0] direct_out,
  output logic [SLOTS-1:0] hard_lost,
  output logic [SLOTS-1:0] fab_lost
);
  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    // sel=1: fabric wins the slot, hard line goes to shared
    assign direct_out[k] = sel[k] ? fab_in[k] : hard_in[k];
    assign hard_lost[k]  = sel[k] & hard_in[k];
    assign fab_lost[k]   = ~sel[k] & fab_in[k];
  end
endmodule

// File: rtl/girt_shared_merge.sv
module girt_shared_merge
  import girt_pkg::*;
#(
  parameter int unsigned C0_LINES = 14,
  parameter int unsigned SLOTS    = 32
) (
  input  logic [SLOTS-1:0] hard_lost,
  input  logic [SLOTS-1:0] fab_lost,
  output logic [2:0]       shared_out
);
  always_comb begin
    shared_out         = '0;
    shared_out[SH_C0]  = |hard_lost[C0_LINES-1:0];
    shared_out[SH_C1]  = |hard_lost[SLOTS-1:C0_LINES];
    shared_out[SH_FAB] = |fab_lost;
  end
endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
  import girt_pkg::*;
#(
  parameter int unsigned C0_LINES = C0_LINES_DEF,
  parameter int unsigned C1_LINES = C1_LINES_DEF,
  parameter int unsigned C1_MUXED = C1_MUXED_DEF,
  parameter int unsigned C2_LINES = C2_LINES_DEF,
  localparam int unsigned SLOTS    = C0_LINES + C1_MUXED,
  localparam int unsigned N_DIRECT = SLOTS + C1_LINES - C1_MUXED
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [SLOTS-1:0]    cfg_wdata,
  output logic [SLOTS-1:0]    cfg_rdata,
  input  logic [C0_LINES-1:0] irq_c0,
  input  logic [C1_LINES-1:0] irq_c1,
  input  logic [C2_LINES-1:0] irq_c2,
  output logic [N_DIRECT-1:0] direct_irq,
  output logic [2:0]          shared_irq
);
  logic [SLOTS-1:0] sel;
  logic [SLOTS-1:0] hard_vec;
  logic [SLOTS-1:0] slot_direct;
  logic [SLOTS-1:0] hard_lost;
  logic [SLOTS-1:0] fab_lost;

  girt_cfg_reg #(.WIDTH(SLOTS)) u_reg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .q(sel)
  );

  assign cfg_rdata = sel;
  assign hard_vec  = {irq_c1[C1_MUXED-1:0], irq_c0};

  girt_pair_steer #(.SLOTS(SLOTS)) u_steer (
    .sel(sel), .hard_in(hard_vec), .fab_in(irq_c2[SLOTS-1:0]),
    .direct_out(slot_direct), .hard_lost(hard_lost), .fab_lost(fab_lost)
  );

  girt_shared_merge #(.C0_LINES(C0_LINES), .SLOTS(SLOTS)) u_merge (
    .hard_lost(hard_lost), .fab_lost(fab_lost), .shared_out(shared_irq)
  );

  assign direct_irq = {irq_c1[C1_LINES-1:C1_MUXED], slot_direct};
endmodule

// File: rtl/gpio_irq_router_chk.sv
module gpio_irq_router_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic [31:0] cfg_wdata,
  input logic [31:0] cfg_rdata,
  input logic [13:0] irq_c0,
  input logic [23:0] irq_c1,
  input logic [31:0] irq_c2,
  input logic [37:0] direct_irq,
  input logic [2:0]  shared_irq
);
  a_r1_reset_clear: assert property (@(posedge clk) !rst_n |=> cfg_rdata == 32'd0);

  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_rdata == $past(cfg_wdata));

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(cfg_rdata));

  a_r6_fixed_direct: assert property (@(posedge clk) disable iff (!rst_n)
    direct_irq[37:32] == irq_c1[23:18]);

  for (genvar k = 0; k < 14; k++) begin : g_c0
    a_r4_c0_slot: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_rdata[k] |-> direct_irq[k] == irq_c0[k]);
    a_r5_c0_slot: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rdata[k] |-> direct_irq[k] == irq_c2[k]);
  end

  for (genvar k = 14; k < 32; k++) begin : g_c1
    a_r4_c1_slot: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_rdata[k] |-> direct_irq[k] == irq_c1[k-14]);
    a_r5_c1_slot: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rdata[k] |-> direct_irq[k] == irq_c2[k]);
  end

  a_r7_no_hard_lines: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_c0 == 14'd0 && irq_c1[17:0] == 18'd0) |-> shared_irq[1:0] == 2'b00);

  a_r8_fabric_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_c2 & ~cfg_rdata) == 32'd0 |-> !shared_irq[2]);
endmodule

bind gpio_irq_router gpio_irq_router_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata), .irq_c0(irq_c0), .irq_c1(irq_c1), .irq_c2(irq_c2),
  .direct_irq(direct_irq), .shared_irq(shared_irq)
);

// File: tb/sim_gpio_irq_router.sv
module sim_gpio_irq_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [13:0] irq_c0 = '0;
  logic [23:0] irq_c1 = '0;
  logic [31:0] irq_c2 = '0;
  logic [37:0] direct_irq;
  logic [2:0]  shared_irq;

  int checks = 0;
  int failures = 0;
  logic [31:0] model_sel = '0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpio_irq_router u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .irq_c0(irq_c0), .irq_c1(irq_c1), .irq_c2(irq_c2),
    .direct_irq(direct_irq), .shared_irq(shared_irq)
  );

  function automatic logic [37:0] exp_direct(input logic [31:0] s, input logic [13:0] a,
                                             input logic [23:0] b, input logic [31:0] f);
    logic [37:0] r;
    for (int k = 0; k < 38; k++) begin
      if (k >= 32)      r[k] = b[k-14];
      else if (s[k])    r[k] = f[k];
      else if (k < 14)  r[k] = a[k];
      else              r[k] = b[k-14];
    end
    return r;
  endfunction

  function automatic logic [2:0] exp_shared(input logic [31:0] s, input logic [13:0] a,
                                            input logic [23:0] b, input logic [31:0] f);
    logic [2:0] r = 3'b000;
    for (int n = 0; n < 14; n++) if (a[n] && s[n]) r[0] = 1'b1;
    for (int n = 0; n < 18; n++) if (b[n] && s[n+14]) r[1] = 1'b1;
    for (int n = 0; n < 32; n++) if (f[n] && !s[n]) r[2] = 1'b1;
    return r;
  endfunction

  task automatic check_routes(input string tag);
    logic [37:0] ed;
    logic [2:0]  es;
    #1;
    ed = exp_direct(model_sel, irq_c0, irq_c1, irq_c2);
    es = exp_shared(model_sel, irq_c0, irq_c1, irq_c2);
    checks++;
    if (direct_irq !== ed) begin
      failures++;
      $display("FAIL %s R4/R5/R6 direct actual=%h expected=%h", tag, direct_irq, ed);
    end
    checks++;
    if (shared_irq !== es) begin
      failures++;
      $display("FAIL %s R7/R8 shared actual=%b expected=%b", tag, shared_irq, es);
    end
  endtask

  task automatic check_reg(input string tag);
    checks++;
    if (cfg_rdata !== model_sel) begin
      failures++;
      $display("FAIL %s readback actual=%h expected=%h", tag, cfg_rdata, model_sel);
    end
  endtask

  task automatic write_reg(input logic [31:0] v);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    cfg_wdata = ~v;
    model_sel = v;
    check_reg("R2 write");
  endtask

  task automatic set_lines(input int line);
    irq_c0 = '0; irq_c1 = '0; irq_c2 = '0;
    if (line < 14)      irq_c0[line] = 1'b1;
    else if (line < 38) irq_c1[line-14] = 1'b1;
    else                irq_c2[line-38] = 1'b1;
  endtask

  task automatic sweep_single(input string tag);
    for (int line = 0; line < 70; line++) begin
      @(negedge clk);
      set_lines(line);
      check_routes(tag);
    end
  endtask

  initial begin
    void'($urandom(32'd20240613));
    repeat (3) @(negedge clk);
    check_reg("R1 reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_reg("R1 after reset");
    sweep_single("R4 R6 sel=0");

    write_reg(32'hFFFF_FFFF);
    sweep_single("R5 R6 sel=1");

    write_reg(32'hA5A5_3C3C);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check_reg("R3 hold");
    end

    // R9: input change reflected with no clock edge in between
    @(negedge clk);
    irq_c0 = 14'h0001; irq_c1 = '0; irq_c2 = '0;
    check_routes("R9 first");
    irq_c2 = 32'h0000_0002;
    check_routes("R9 second");

    for (int i = 0; i < 200; i++) begin
      write_reg($urandom());
      for (int j = 0; j < 4; j++) begin
        @(negedge clk);
        irq_c0 = 14'($urandom());
        irq_c1 = 24'($urandom());
        irq_c2 = $urandom();
        check_routes("R7 R8 random");
      end
    end
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule